// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt requests for a small 8-bit microcontroller core and turns them into a single vector request toward the CPU. There are five sources: two external active-low pins, two timer overflow strobes and one serial-frame event. Each source keeps a pending flag that is set and cleared by rules of its own. Individual enable bits and one global enable gate which flags may request service. A per-source priority bit places each source at the high or low level.

The controller tracks which levels are in service with two in-service bits. It grants a new request only when the request's level is above every level already active. Within a level, a fixed ordering of source indices breaks ties. The CPU answers a request with an acknowledge strobe, which marks the level as in service and clears the flags of self-clearing sources. A return strobe ends the innermost active service routine.

Source indices, which are also the vector numbers, are: 0 = external pin A, 1 = timer A, 2 = external pin B, 3 = timer B, 4 = serial unit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, all pending flags, enables, priorities and in-service bits are 0, and both external inputs are in level mode. No request is raised and the vector output is 0.
- R2: When mode bit g is 1 (edge mode), a falling edge on external pin g, seen after a two-flop synchronizer, sets pending flag 2*g. The flag stays set after the pin returns high and is cleared when its vector is acknowledged.
- R3: When mode bit g is 0 (level mode), pending flag 2*g equals the inverse of the synchronized pin. Acknowledging its vector does not clear it.
- R4: A strobe on timer overflow input g sets pending flag 2*g+1. Acknowledging vector 2*g+1 clears that flag.
- R5: A transmit-done or an error-free receive-done strobe sets pending flag 4. A receive-done that carries the error flag does not set it. Only the clear strobe clears the flag; acknowledging vector 4 leaves it set.
- R6: A pending flag can request only when its enable bit (enable bit i for source i) and the global enable (enable bit 5) are both 1. Pending flags are reported whatever the enables are.
- R7: Among enabled pending sources at the same level, the lowest source index wins, and the vector output equals that index.
- R8: An enabled high-level source (priority bit i = 1) wins over every low-level source, whatever its index. The level output is 1 for a high-level grant.
- R9: An acknowledge during a request sets the in-service bit of the granted level (bit 1 = high, bit 0 = low). While the low bit alone is set, only high-level sources can request.
- R10: While the high in-service bit is set, no request is raised.
- R11: A return strobe clears the high in-service bit if it is set, and otherwise clears the low bit.
- R12: An acknowledge while no request is raised changes neither the in-service bits nor any pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_n_i | input | 2 | External request pins, active low |
| tmr_ovf_i | input | 2 | Timer overflow strobes |
| ser_tx_done_i | input | 1 | Serial frame transmitted strobe |
| ser_rx_done_i | input | 1 | Serial frame received strobe |
| ser_rx_err_i | input | 1 | Error qualifier for the received frame |
| ser_clr_i | input | 1 | Software clear of the serial pending flag |
| en_we_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 6 | Enable data: bits 4..0 per source, bit 5 global |
| pri_we_i | input | 1 | Priority register write strobe |
| pri_wdata_i | input | 5 | Priority data, 1 = high level |
| mode_we_i | input | 1 | External mode register write strobe |
| mode_wdata_i | input | 2 | Mode data, 1 = falling edge, 0 = low level |
| ack_i | input | 1 | CPU vector acknowledge strobe |
| reti_i | input | 1 | CPU return-from-interrupt strobe |
| irq_req_o | output | 1 | Vector request to the CPU |
| irq_vec_o | output | 3 | Source index of the request |
| irq_lvl_o | output | 1 | Level of the request, 1 = high |
| pend_o | output | 5 | Pending flags per source |
| insvc_o | output | 2 | In-service bits, bit 1 = high level |

## Verification
A wrong in-service bit shows on the first cycle it is wrong. Requests are either blocked where the model grants them, or granted with the wrong level. A wrong flag-clearing rule shows on pend_o one cycle after the acknowledge or clear strobe that should or should not have touched it. A fault in the arbitration shows at once as a wrong vector or level. This holds because the request path is combinational from the registers, and the bench sweeps every enable and priority pattern against all five pending sources in each in-service state.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NSRC = 5;
  localparam int unsigned NEXT = 2;
  localparam int unsigned VW   = $clog2(NSRC);
  localparam int unsigned EW   = NSRC + 1;
  localparam int unsigned SER_IDX = NSRC - 1;

  typedef enum logic [VW-1:0] {
    SRC_EXT_A = 3'd0,
    SRC_TMR_A = 3'd1,
    SRC_EXT_B = 3'd2,
    SRC_TMR_B = 3'd3,
    SRC_SER   = 3'd4
  } src_e;
endpackage

// File: rtl/irq_ext_src.sv
module irq_ext_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic edge_mode,
  input  logic vec_clr,
  output logic pend_o
);
  localparam int unsigned MSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   flag_q;
  logic                   flag_d;
  logic                   fell;

  assign fell = prev_q & ~sync_q[MSB];

  always_comb begin
    flag_d = flag_q;
    if (!edge_mode)  flag_d = 1'b0;
    else if (fell)   flag_d = 1'b1;
    else if (vec_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      flag_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      prev_q <= sync_q[MSB];
      flag_q <= flag_d;
    end
  end

  assign pend_o = edge_mode ? flag_q : ~sync_q[MSB];

  assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && fell) |=> (pend_o || !edge_mode));

  assert_edge_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && vec_clr && !fell) |=> !flag_q);
endmodule

// File: rtl/irq_flag.sv
module irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_i)      flag_d = 1'b1;
    else if (clr_i) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] cand_i,
  input  logic [NSRC-1:0] pri_i,
  input  logic [1:0]      insvc_i,
  output logic            req_o,
  output logic [VW-1:0]   vec_o,
  output logic            lvl_o
);
  logic [NSRC-1:0] hi;
  logic [NSRC-1:0] lo;

  function automatic logic [VW-1:0] first_idx(input logic [NSRC-1:0] v);
    logic [VW-1:0] idx;
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) idx = VW'(i);
    end
    return idx;
  endfunction

  assign hi = cand_i & pri_i;
  assign lo = cand_i & ~pri_i;

  always_comb begin
    req_o = 1'b0;
    vec_o = '0;
    lvl_o = 1'b0;
    if (!insvc_i[1]) begin
      if (|hi) begin
        req_o = 1'b1;
        lvl_o = 1'b1;
        vec_o = first_idx(hi);
      end else if (!insvc_i[0] && (|lo)) begin
        req_o = 1'b1;
        vec_o = first_idx(lo);
      end
    end
  end

  assert_req_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> cand_i[vec_o]);

  assert_hi_blocks_all_R10: assert property (@(posedge clk) disable iff (!rst_n)
    insvc_i[1] |-> !req_o);

  assert_lo_only_hi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && insvc_i[0]) |-> lvl_o);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NEXT-1:0] ext_n_i,
  input  logic [NEXT-1:0] tmr_ovf_i,
  input  logic            ser_tx_done_i,
  input  logic            ser_rx_done_i,
  input  logic            ser_rx_err_i,
  input  logic            ser_clr_i,
  input  logic            en_we_i,
  input  logic [EW-1:0]   en_wdata_i,
  input  logic            pri_we_i,
  input  logic [NSRC-1:0] pri_wdata_i,
  input  logic            mode_we_i,
  input  logic [NEXT-1:0] mode_wdata_i,
  input  logic            ack_i,
  input  logic            reti_i,
  output logic            irq_req_o,
  output logic [VW-1:0]   irq_vec_o,
  output logic            irq_lvl_o,
  output logic [NSRC-1:0] pend_o,
  output logic [1:0]      insvc_o
);
  logic [EW-1:0]   en_q,   en_d;
  logic [NSRC-1:0] pri_q,  pri_d;
  logic [NEXT-1:0] mode_q, mode_d;
  logic [1:0]      insvc_q, insvc_d;

  logic            acc;
  logic [NSRC-1:0] vec_hit;
  logic [NSRC-1:0] cand;
  logic            ser_set;

  assign acc     = ack_i & irq_req_o;
  assign vec_hit = acc ? (NSRC'(1) << irq_vec_o) : '0;
  assign ser_set = ser_tx_done_i | (ser_rx_done_i & ~ser_rx_err_i);

  // next state for configuration and in-service tracking
  always_comb begin
    en_d    = en_we_i   ? en_wdata_i   : en_q;
    pri_d   = pri_we_i  ? pri_wdata_i  : pri_q;
    mode_d  = mode_we_i ? mode_wdata_i : mode_q;
    insvc_d = insvc_q;
    if (reti_i) begin
      if (insvc_q[1]) insvc_d[1] = 1'b0;
      else            insvc_d[0] = 1'b0;
    end
    if (acc) insvc_d[irq_lvl_o] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      pri_q   <= '0;
      mode_q  <= '0;
      insvc_q <= '0;
    end else begin
      en_q    <= en_d;
      pri_q   <= pri_d;
      mode_q  <= mode_d;
      insvc_q <= insvc_d;
    end
  end

  for (genvar g = 0; g < NEXT; g++) begin : g_pair
    irq_ext_src #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_n     (ext_n_i[g]),
      .edge_mode (mode_q[g]),
      .vec_clr   (vec_hit[2*g]),
      .pend_o    (pend_o[2*g])
    );
    irq_flag u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (tmr_ovf_i[g]),
      .clr_i  (vec_hit[2*g+1]),
      .flag_o (pend_o[2*g+1])
    );
  end

  irq_flag u_ser (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ser_set),
    .clr_i  (ser_clr_i),
    .flag_o (pend_o[SER_IDX])
  );

  assign cand = pend_o & en_q[NSRC-1:0] & {NSRC{en_q[NSRC]}};

  irq_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand_i  (cand),
    .pri_i   (pri_q),
    .insvc_i (insvc_q),
    .req_o   (irq_req_o),
    .vec_o   (irq_vec_o),
    .lvl_o   (irq_lvl_o)
  );

  assign insvc_o = insvc_q;

  assert_vec_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req_o |-> (irq_vec_o < VW'(NSRC)));

  assert_tmr_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && irq_vec_o == VW'(1) && !tmr_ovf_i[0]) |=> !pend_o[1]);

  assert_rx_err_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_rx_done_i && ser_rx_err_i && !ser_tx_done_i && !pend_o[SER_IDX])
      |=> !pend_o[SER_IDX]);

  assert_reti_nested_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && !ack_i && insvc_q == 2'b11) |=> (insvc_q == 2'b01));

  assert_stray_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_req_o && !reti_i) |=> $stable(insvc_q));
endmodule

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] ext_n, tmr_ovf, mode_wdata;
  logic       ser_tx, ser_rx, ser_err, ser_clr;
  logic       en_we, pri_we, mode_we, ack, reti;
  logic [5:0] en_wdata;
  logic [4:0] pri_wdata;
  logic       irq_req, irq_lvl;
  logic [2:0] irq_vec;
  logic [4:0] pend;
  logic [1:0] insvc;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_n_i(ext_n), .tmr_ovf_i(tmr_ovf),
    .ser_tx_done_i(ser_tx), .ser_rx_done_i(ser_rx), .ser_rx_err_i(ser_err),
    .ser_clr_i(ser_clr), .en_we_i(en_we), .en_wdata_i(en_wdata),
    .pri_we_i(pri_we), .pri_wdata_i(pri_wdata), .mode_we_i(mode_we),
    .mode_wdata_i(mode_wdata), .ack_i(ack), .reti_i(reti),
    .irq_req_o(irq_req), .irq_vec_o(irq_vec), .irq_lvl_o(irq_lvl),
    .pend_o(pend), .insvc_o(insvc)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] want);
    n_chk++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, want);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // expected {req, lvl, vec} from the requirements
  function automatic logic [4:0] model(input logic [4:0] p, input logic [4:0] e,
                                       input logic [4:0] pr, input logic [1:0] ins);
    logic [4:0] c, h, l;
    logic [2:0] v;
    c = p & e; h = c & pr; l = c & ~pr;
    v = 3'd0;
    if (ins[1]) return 5'b0;
    if (h != 0) begin
      for (int i = 4; i >= 0; i--) if (h[i]) v = 3'(i);
      return {2'b11, v};
    end
    if (!ins[0] && l != 0) begin
      for (int i = 4; i >= 0; i--) if (l[i]) v = 3'(i);
      return {2'b10, v};
    end
    return 5'b0;
  endfunction

  task automatic cfg(input logic [5:0] e, input logic [4:0] p);
    en_we = 1'b1; en_wdata = e; pri_we = 1'b1; pri_wdata = p;
    tick(1);
    en_we = 1'b0; pri_we = 1'b0;
  endtask

  task automatic strobe_ack;  ack = 1'b1;  tick(1); ack = 1'b0;  endtask
  task automatic strobe_reti; reti = 1'b1; tick(1); reti = 1'b0; endtask

  task automatic sweep(input string tag, input logic [1:0] ins);
    for (int e = 0; e < 32; e++) begin
      for (int p = 0; p < 32; p++) begin
        cfg({1'b1, 5'(e)}, 5'(p));
        chk(tag, {3'b0, irq_req, irq_lvl, irq_vec}, {3'b0, model(pend, 5'(e), 5'(p), ins)});
      end
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_n = 2'b11; tmr_ovf = 2'b00; mode_wdata = 2'b00;
    ser_tx = 0; ser_rx = 0; ser_err = 0; ser_clr = 0;
    en_we = 0; pri_we = 0; mode_we = 0; ack = 0; reti = 0;
    en_wdata = '0; pri_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1", {3'b0, pend}, 8'h00);
    chk("R1", {6'b0, insvc}, 8'h00);
    chk("R1", {4'b0, irq_req, irq_vec}, 8'h00);
    cfg(6'h3F, 5'h00);
    chk("R1", {7'b0, irq_req}, 8'h00);

    // R3 level mode follows pin
    ext_n = 2'b00;
    tick(3);
    chk("R3", {6'b0, pend[2], pend[0]}, 8'h03);
    tmr_ovf = 2'b11; ser_tx = 1'b1; tick(1); tmr_ovf = 2'b00; ser_tx = 1'b0;
    chk("R4", {3'b0, pend}, 8'h1F);

    // R6 global enable off masks all
    cfg(6'h1F, 5'h00);
    chk("R6", {7'b0, irq_req}, 8'h00);
    chk("R6", {3'b0, pend}, 8'h1F);

    // R7 R8 exhaustive enable x priority with nothing in service
    sweep("R7_R8", 2'b00);

    // R9 low level in service: ext A level source, ack must not clear it (R3)
    cfg(6'h3F, 5'h00);
    chk("R7", {4'b0, irq_req, irq_vec}, 8'h08);
    strobe_ack();
    chk("R9", {6'b0, insvc}, 8'h01);
    chk("R3", {7'b0, pend[0]}, 8'h01);
    sweep("R9", 2'b01);

    // R10 high in service blocks everything
    cfg(6'h3F, 5'h01);
    chk("R8", {6'b0, irq_req, irq_lvl}, 8'h03);
    strobe_ack();
    chk("R9", {6'b0, insvc}, 8'h03);
    for (int p = 0; p < 32; p++) begin
      cfg(6'h3F, 5'(p));
      chk("R10", {7'b0, irq_req}, 8'h00);
    end

    // R11 return unwinds high then low
    strobe_reti();
    chk("R11", {6'b0, insvc}, 8'h01);
    strobe_reti();
    chk("R11", {6'b0, insvc}, 8'h00);

    // R12 stray acknowledge
    cfg(6'h20, 5'h00);
    chk("R12", {7'b0, irq_req}, 8'h00);
    strobe_ack();
    chk("R12", {6'b0, insvc}, 8'h00);
    chk("R12", {3'b0, pend}, 8'h1F);

    // R4 timer A cleared by its acknowledge
    cfg(6'h22, 5'h00);
    chk("R4", {4'b0, irq_req, irq_vec}, 8'h09);
    strobe_ack();
    chk("R4", {7'b0, pend[1]}, 8'h00);
    chk("R4", {7'b0, pend[3]}, 8'h01);
    strobe_reti();

    // R5 serial flag
    cfg(6'h30, 5'h00);
    chk("R5", {4'b0, irq_req, irq_vec}, 8'h0C);
    strobe_ack();
    chk("R5", {7'b0, pend[4]}, 8'h01);
    strobe_reti();
    ser_clr = 1'b1; tick(1); ser_clr = 1'b0;
    chk("R5", {7'b0, pend[4]}, 8'h00);
    ser_rx = 1'b1; ser_err = 1'b1; tick(1); ser_rx = 1'b0; ser_err = 1'b0;
    chk("R5", {7'b0, pend[4]}, 8'h00);
    ser_rx = 1'b1; tick(1); ser_rx = 1'b0;
    chk("R5", {7'b0, pend[4]}, 8'h01);

    // R2 edge mode on external pin A
    ext_n = 2'b11;
    tick(4);
    chk("R3", {6'b0, pend[2], pend[0]}, 8'h00);
    mode_we = 1'b1; mode_wdata = 2'b01; tick(1); mode_we = 1'b0;
    chk("R2", {7'b0, pend[0]}, 8'h00);
    ext_n = 2'b10;
    tick(4);
    chk("R2", {7'b0, pend[0]}, 8'h01);
    ext_n = 2'b11;
    tick(4);
    chk("R2", {7'b0, pend[0]}, 8'h01);
    cfg(6'h21, 5'h00);
    chk("R2", {4'b0, irq_req, irq_vec}, 8'h08);
    strobe_ack();
    chk("R2", {7'b0, pend[0]}, 8'h00);
    strobe_reti();
    chk("R11", {6'b0, insvc}, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule